// File: doc/BRIEF.md
# Multi-Source System Clock Generator

This block derives three system clocks from up to three oscillator inputs: a main clock for the processor, a sub-main clock for peripherals, and an auxiliary clock. The oscillators are a digitally controlled oscillator (DCO), a first crystal oscillator and an optional second crystal oscillator. All three arrive as level inputs and are oversampled by a fast reference clock. Each output has its own source multiplexer, its own power-of-two divider and its own run/stop gate. A source or divider change waits until the output and both the old and the new source are low. This means no runt pulse reaches the clock consumers.

Two byte-wide control registers are reached through a simple write strobe and a combinational read port. The block also computes an enable request for each oscillator and for the DC generator that biases the DCO. A software "off" request for an oscillator is overridden while that oscillator feeds a running main or sub-main clock. A build parameter selects a two-oscillator or a three-oscillator system. In the two-oscillator build, the first crystal takes the place of the absent second crystal in the select decoding.

Top module: `sysclk_gen`

## Requirements
- R1: After reset, register 0 reads 0x0C and register 1 reads 0x00. In register 0, bits 2:0 are the bias-resistor select (reset 4), bit 3 is the second-crystal off request (reset 1), bits 5:4 are the auxiliary divider and bits 7:6 are reserved. In register 1, bits 1:0 are the main select, bits 3:2 the main divider, bit 4 the sub-main select, bits 6:5 the sub-main divider, and bit 7 is reserved. With these reset values, the main and sub-main clocks run from the DCO undivided.
- R2: A write stores wr_data into the register chosen by wr_addr (0 or 1). Reserved bits always read 0, so writing 0xFF gives 0x3F in register 0 and 0x7F in register 1.
- R3: The main select chooses its source as follows: 0 and 1 choose the DCO; 3 chooses the first crystal; 2 chooses the second crystal, or the first crystal in the two-oscillator build.
- R4: The sub-main select chooses its source as follows: 0 chooses the DCO; 1 chooses the second crystal, or the first crystal in the two-oscillator build.
- R5: Divider codes 0 to 3 divide the source by 1, 2, 4 and 8. Every divided output has a 50 percent duty cycle.
- R6: The auxiliary clock always comes from the first crystal through its own divider, whatever the main and sub-main settings are.
- R7: While cpu_off is 1 the main clock stays low, and while smclk_off is 1 the sub-main clock stays low. The auxiliary clock keeps running in both cases.
- R8: In the three-oscillator build, xt2_en is 1 when the second-crystal off bit is 0, when the main clock runs with select 2, or when the sub-main clock runs with select 1. In the two-oscillator build, xt2_en is always 0.
- R9: xt1_en is 1 when xt1_off is 0, or when the first crystal feeds a running main or sub-main clock.
- R10: dco_en is 1 exactly when the main clock runs with select bit 1 clear, or when the sub-main clock runs with select 0. dcgen_en is 1 when dco_en is 1 or dcgen_off is 0.
- R11: A source or divider change only takes effect while the output and both the old and the new source are low. The divider restarts from zero at that point, so no high pulse is shorter than the shortest source half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock that oversamples the oscillators |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_dco | input | 1 | DCO oscillator level |
| osc_xt1 | input | 1 | First crystal oscillator level |
| osc_xt2 | input | 1 | Second crystal oscillator level |
| cpu_off | input | 1 | Stops the main clock |
| smclk_off | input | 1 | Stops the sub-main clock |
| dcgen_off | input | 1 | Requests the DC generator off |
| xt1_off | input | 1 | Requests the first crystal off |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register index for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Register index for reads |
| rd_data | output | 8 | Read data of the addressed register |
| mclk | output | 1 | Main clock |
| smclk | output | 1 | Sub-main clock |
| aclk | output | 1 | Auxiliary clock |
| dco_en | output | 1 | DCO run request |
| dcgen_en | output | 1 | DC generator run request |
| xt1_en | output | 1 | First crystal run request |
| xt2_en | output | 1 | Second crystal run request |

## Verification
The bench builds two copies side by side, one with THREE_OSC=1 and one with THREE_OSC=0, and drives both with the same oscillator levels and register writes. This exposes the remapped select values and the permanently idle second-crystal request in the two-oscillator build. The oscillator half-periods are 4, 10 and 6 reference cycles. This makes every source and divider combination produce a distinct, exactly predictable period, and gives a known minimum high width for the runt-pulse check during rapid reselection.

// File: rtl/sysclk_pkg.sv
// Shared types and source-decoding helpers for the system clock generator.
// Assumes the oscillator index order DCO=0, first crystal=1, second crystal=2.
package sysclk_pkg;

    typedef enum logic [1:0] {
        SRC_DCO = 2'd0,
        SRC_XT1 = 2'd1,
        SRC_XT2 = 2'd2
    } src_e;

    localparam int NUM_OSC = 3;
    localparam int NUM_CH  = 3;
    localparam int CH_MAIN = 0;
    localparam int CH_SUB  = 1;
    localparam int CH_AUX  = 2;

    // Decode the 2-bit main select into a source.
    function automatic src_e main_source(input logic [1:0] sel, input bit three_osc);
        src_e s;
        case (sel)
            2'd2:    s = three_osc ? SRC_XT2 : SRC_XT1;
            2'd3:    s = SRC_XT1;
            default: s = SRC_DCO;
        endcase
        return s;
    endfunction

    // Decode the 1-bit sub-main select into a source.
    function automatic src_e sub_source(input logic sel, input bit three_osc);
        src_e s;
        if (!sel)          s = SRC_DCO;
        else if (three_osc) s = SRC_XT2;
        else               s = SRC_XT1;
        return s;
    endfunction

endpackage

// File: rtl/sysclk_regs.sv
// Two byte-wide control registers with a write strobe and a combinational read.
// Register 0: [2:0] bias select, [3] second-crystal off, [5:4] aux divider.
// Register 1: [1:0] main select, [3:2] main divider, [4] sub select, [6:5] sub divider.
// Assumes writes are synchronous to clk; reserved bits read as zero.
module sysclk_regs #(
    parameter int          DIV_W     = 2,
    parameter logic [2:0]  RSEL_INIT = 3'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             rd_addr,
    output logic [7:0]       rd_data,
    output logic             xt2_off,
    output logic [DIV_W-1:0] aux_div,
    output logic [1:0]       main_sel,
    output logic [DIV_W-1:0] main_div,
    output logic             sub_sel,
    output logic [DIV_W-1:0] sub_div,
    output logic             wr_osc,
    output logic             wr_sys
);
    logic [2:0] rsel_q;

    assign wr_osc = wr_en && !wr_addr;
    assign wr_sys = wr_en &&  wr_addr;

    // Oscillator control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q  <= RSEL_INIT;
            xt2_off <= 1'b1;
            aux_div <= '0;
        end else if (wr_osc) begin
            rsel_q  <= wr_data[2:0];
            xt2_off <= wr_data[3];
            aux_div <= wr_data[4 +: DIV_W];
        end
    end

    // System clock control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_sel <= '0;
            main_div <= '0;
            sub_sel  <= 1'b0;
            sub_div  <= '0;
        end else if (wr_sys) begin
            main_sel <= wr_data[1:0];
            main_div <= wr_data[2 +: DIV_W];
            sub_sel  <= wr_data[4];
            sub_div  <= wr_data[5 +: DIV_W];
        end
    end

    // Read multiplexer with reserved bits forced to zero.
    always_comb begin
        rd_data = '0;
        if (!rd_addr) begin
            rd_data[2:0]         = rsel_q;
            rd_data[3]           = xt2_off;
            rd_data[4 +: DIV_W]  = aux_div;
        end else begin
            rd_data[1:0]         = main_sel;
            rd_data[2 +: DIV_W]  = main_div;
            rd_data[4]           = sub_sel;
            rd_data[5 +: DIV_W]  = sub_div;
        end
    end

endmodule

// File: rtl/sysclk_osc_ctl.sv
// Oscillator and DC-generator run requests. A software off request is
// overridden while the oscillator feeds a running main or sub-main clock.
// Assumes the gating inputs are synchronous to the reference clock.
module sysclk_osc_ctl
    import sysclk_pkg::*;
#(
    parameter bit THREE_OSC = 1'b1
) (
    input  logic [1:0] main_sel,
    input  logic       sub_sel,
    input  logic       cpu_off,
    input  logic       smclk_off,
    input  logic       xt1_off,
    input  logic       xt2_off,
    input  logic       dcgen_off,
    output logic       xt1_en,
    output logic       xt2_en,
    output logic       dco_en,
    output logic       dcgen_en
);
    src_e m_src;
    src_e s_src;
    logic main_run;
    logic sub_run;

    // Work out which source each running clock needs and raise requests.
    always_comb begin
        m_src    = main_source(main_sel, THREE_OSC);
        s_src    = sub_source(sub_sel, THREE_OSC);
        main_run = !cpu_off;
        sub_run  = !smclk_off;
        xt1_en   = !xt1_off || (main_run && m_src == SRC_XT1) || (sub_run && s_src == SRC_XT1);
        xt2_en   = THREE_OSC &&
                   (!xt2_off || (main_run && m_src == SRC_XT2) || (sub_run && s_src == SRC_XT2));
        dco_en   = (main_run && m_src == SRC_DCO) || (sub_run && s_src == SRC_DCO);
        dcgen_en = dco_en || !dcgen_off;
    end

endmodule

// File: rtl/sysclk_chan.sv
// One clock output channel: source multiplexer, power-of-two divider and gate.
// A pending reconfiguration is applied only while the output and both the old
// and new sources are low; the divider then restarts from zero. The gate is
// only updated while the divided phase is low, so pulses are never cut short.
// Assumes source levels are already synchronised to clk.
module sysclk_chan
    import sysclk_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] src_lvl,
    input  src_e               req_src,
    input  logic [DIV_W-1:0]   req_div,
    input  logic               reload,
    input  logic               run,
    output logic               clk_o,
    output logic               sw_o
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    src_e             cur_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] cnt_sh;
    logic             prev_q;
    logic             ph_q;
    logic             ph_nx;
    logic             en_q;
    logic             en_nx;
    logic             pend_q;
    logic             cur_lvl;
    logic             new_lvl;
    logic             rise;

    // Pick the level of a given source.
    function automatic logic pick(input logic [NUM_OSC-1:0] lvl, input src_e s);
        case (s)
            SRC_XT1: return lvl[1];
            SRC_XT2: return lvl[2];
            default: return lvl[0];
        endcase
    endfunction

    // Next divider state and switch decision.
    always_comb begin
        cur_lvl = pick(src_lvl, cur_q);
        new_lvl = pick(src_lvl, req_src);
        rise    = cur_lvl && !prev_q;
        sw_o    = pend_q && !ph_q && !cur_lvl && !new_lvl;
        cnt_nx  = rise ? cnt_q + 1'b1 : cnt_q;
        cnt_sh  = cnt_nx >> (div_q - 1'b1);
        if (sw_o)             ph_nx = 1'b0;
        else if (div_q == '0) ph_nx = cur_lvl;
        else                  ph_nx = cnt_sh[0];
        en_nx   = ph_q ? en_q : run;
    end

    // Divider, phase, gate and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= SRC_DCO;
            div_q  <= '0;
            cnt_q  <= '0;
            prev_q <= 1'b0;
            ph_q   <= 1'b0;
            en_q   <= 1'b0;
            pend_q <= 1'b1;
            clk_o  <= 1'b0;
        end else begin
            en_q  <= en_nx;
            clk_o <= ph_nx && en_nx;
            ph_q  <= ph_nx;
            if (sw_o) begin
                cur_q  <= req_src;
                div_q  <= req_div;
                cnt_q  <= '0;
                prev_q <= new_lvl;
                pend_q <= reload;
            end else begin
                cnt_q  <= cnt_nx;
                prev_q <= cur_lvl;
                if (reload) pend_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysclk_gen.sv
// Top of the multi-source system clock generator. Synchronises the three
// oscillator levels, holds the control registers, raises oscillator run
// requests and drives three glitch-free divided and gated clock outputs.
// Assumes clk is several times faster than the fastest oscillator.
module sysclk_gen
    import sysclk_pkg::*;
#(
    parameter bit THREE_OSC   = 1'b1,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_dco,
    input  logic       osc_xt1,
    input  logic       osc_xt2,
    input  logic       cpu_off,
    input  logic       smclk_off,
    input  logic       dcgen_off,
    input  logic       xt1_off,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    output logic       mclk,
    output logic       smclk,
    output logic       aclk,
    output logic       dco_en,
    output logic       dcgen_en,
    output logic       xt1_en,
    output logic       xt2_en
);
    logic [NUM_OSC-1:0]     osc_in;
    logic [NUM_OSC-1:0]     osc_lvl;
    logic [SYNC_STAGES-1:0] sync_q [NUM_OSC];

    logic             cfg_xt2_off;
    logic [DIV_W-1:0] cfg_aux_div;
    logic [1:0]       cfg_main_sel;
    logic [DIV_W-1:0] cfg_main_div;
    logic             cfg_sub_sel;
    logic [DIV_W-1:0] cfg_sub_div;
    logic             wr_osc;
    logic             wr_sys;

    src_e             ch_src    [NUM_CH];
    logic [DIV_W-1:0] ch_div    [NUM_CH];
    logic             ch_reload [NUM_CH];
    logic             ch_run    [NUM_CH];
    logic             ch_out    [NUM_CH];
    logic             ch_sw     [NUM_CH];

    assign osc_in = {osc_xt2, osc_xt1, osc_dco};

    // Bring each oscillator level into the reference clock domain.
    for (genvar g = 0; g < NUM_OSC; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= '0;
            else        sync_q[g] <= {sync_q[g][SYNC_STAGES-2:0], osc_in[g]};
        end
        assign osc_lvl[g] = sync_q[g][SYNC_STAGES-1];
    end

    sysclk_regs #(.DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .xt2_off  (cfg_xt2_off),
        .aux_div  (cfg_aux_div),
        .main_sel (cfg_main_sel),
        .main_div (cfg_main_div),
        .sub_sel  (cfg_sub_sel),
        .sub_div  (cfg_sub_div),
        .wr_osc   (wr_osc),
        .wr_sys   (wr_sys)
    );

    sysclk_osc_ctl #(.THREE_OSC(THREE_OSC)) u_osc_ctl (
        .main_sel  (cfg_main_sel),
        .sub_sel   (cfg_sub_sel),
        .cpu_off   (cpu_off),
        .smclk_off (smclk_off),
        .xt1_off   (xt1_off),
        .xt2_off   (cfg_xt2_off),
        .dcgen_off (dcgen_off),
        .xt1_en    (xt1_en),
        .xt2_en    (xt2_en),
        .dco_en    (dco_en),
        .dcgen_en  (dcgen_en)
    );

    // Per-channel requests: source, divider, reload strobe and run gate.
    always_comb begin
        ch_src[CH_MAIN]    = main_source(cfg_main_sel, THREE_OSC);
        ch_src[CH_SUB]     = sub_source(cfg_sub_sel, THREE_OSC);
        ch_src[CH_AUX]     = SRC_XT1;
        ch_div[CH_MAIN]    = cfg_main_div;
        ch_div[CH_SUB]     = cfg_sub_div;
        ch_div[CH_AUX]     = cfg_aux_div;
        ch_reload[CH_MAIN] = wr_sys;
        ch_reload[CH_SUB]  = wr_sys;
        ch_reload[CH_AUX]  = wr_osc;
        ch_run[CH_MAIN]    = !cpu_off;
        ch_run[CH_SUB]     = !smclk_off;
        ch_run[CH_AUX]     = 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sysclk_chan #(.DIV_W(DIV_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_lvl (osc_lvl),
            .req_src (ch_src[c]),
            .req_div (ch_div[c]),
            .reload  (ch_reload[c]),
            .run     (ch_run[c]),
            .clk_o   (ch_out[c]),
            .sw_o    (ch_sw[c])
        );
    end

    assign mclk  = ch_out[CH_MAIN];
    assign smclk = ch_out[CH_SUB];
    assign aclk  = ch_out[CH_AUX];

endmodule

// File: rtl/sysclk_gen_chk.sv
// Property checker for the system clock generator, bound to every instance.
// Assumes it observes the top-level ports plus the decoded selects and the
// main channel's switch strobe.
module sysclk_gen_chk #(
    parameter bit THREE_OSC = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_off,
    input logic       smclk_off,
    input logic [1:0] main_sel,
    input logic       sub_sel,
    input logic       mclk,
    input logic       smclk,
    input logic       main_sw,
    input logic       xt2_en,
    input logic       dco_en,
    input logic       dcgen_en,
    input logic       rd_addr,
    input logic [7:0] rd_data
);
    // R7
    mclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_off && !mclk) |=> !mclk);

    // R7
    smclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smclk_off && !smclk) |=> !smclk);

    // R8
    xt2_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (THREE_OSC && !cpu_off && main_sel == 2'd2) |-> xt2_en);

    // R8
    xt2_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!THREE_OSC) |-> !xt2_en);

    // R10
    dco_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cpu_off && !main_sel[1]) || (!smclk_off && !sub_sel)) |-> (dco_en && dcgen_en));

    // R10
    dcgen_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dcgen_en |-> !dco_en);

    // R11
    switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_sw |=> !mclk);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr |-> !rd_data[7]);

endmodule

bind sysclk_gen sysclk_gen_chk #(.THREE_OSC(THREE_OSC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_off   (cpu_off),
    .smclk_off (smclk_off),
    .main_sel  (cfg_main_sel),
    .sub_sel   (cfg_sub_sel),
    .mclk      (mclk),
    .smclk     (smclk),
    .main_sw   (ch_sw[0]),
    .xt2_en    (xt2_en),
    .dco_en    (dco_en),
    .dcgen_en  (dcgen_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/sysclk_gen_bench.sv
// Bench: a three-oscillator copy (A) and a two-oscillator copy (B) share stimulus.
module sysclk_gen_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       osc_dco = 1'b0, osc_xt1 = 1'b0, osc_xt2 = 1'b0;
    logic       cpu_off = 1'b0, smclk_off = 1'b0, dcgen_off = 1'b1, xt1_off = 1'b1;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [7:0] wr_data = '0;

    logic [7:0] a_rd, b_rd;
    logic a_mclk, a_smclk, a_aclk, a_dco, a_dcg, a_xt1, a_xt2;
    logic b_mclk, b_smclk, b_aclk, b_dco, b_dcg, b_xt1, b_xt2;

    sysclk_gen #(.THREE_OSC(1'b1)) u_sysclk_gen (
        .clk(clk), .rst_n(rst_n), .osc_dco(osc_dco), .osc_xt1(osc_xt1), .osc_xt2(osc_xt2),
        .cpu_off(cpu_off), .smclk_off(smclk_off), .dcgen_off(dcgen_off), .xt1_off(xt1_off),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(a_rd),
        .mclk(a_mclk), .smclk(a_smclk), .aclk(a_aclk), .dco_en(a_dco), .dcgen_en(a_dcg),
        .xt1_en(a_xt1), .xt2_en(a_xt2));

    sysclk_gen #(.THREE_OSC(1'b0)) u_sysclk_gen_2osc (
        .clk(clk), .rst_n(rst_n), .osc_dco(osc_dco), .osc_xt1(osc_xt1), .osc_xt2(osc_xt2),
        .cpu_off(cpu_off), .smclk_off(smclk_off), .dcgen_off(dcgen_off), .xt1_off(xt1_off),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(b_rd),
        .mclk(b_mclk), .smclk(b_smclk), .aclk(b_aclk), .dco_en(b_dco), .dcgen_en(b_dcg),
        .xt1_en(b_xt1), .xt2_en(b_xt2));

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // Oscillator half-periods in reference cycles: DCO 4, XT1 10, XT2 6.
    initial forever begin repeat (4)  @(negedge clk); osc_dco = ~osc_dco; end
    initial forever begin repeat (10) @(negedge clk); osc_xt1 = ~osc_xt1; end
    initial forever begin repeat (6)  @(negedge clk); osc_xt2 = ~osc_xt2; end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic outsig(input int inst, input int ch);
        if (inst == 0) return (ch == 0) ? a_mclk : (ch == 1) ? a_smclk : a_aclk;
        return (ch == 0) ? b_mclk : (ch == 1) ? b_smclk : b_aclk;
    endfunction

    // Period and high time between two consecutive rising edges.
    task automatic measure(input int inst, input int ch, output int per, output int hi);
        logic p, c;
        int t;
        p = outsig(inst, ch); c = p; t = 0;
        while (t < 3000) begin
            @(negedge clk); t++; c = outsig(inst, ch);
            if (!p && c) break;
            p = c;
        end
        per = 0; hi = 0;
        do begin
            if (c) hi++;
            per++;
            @(negedge clk); p = c; c = outsig(inst, ch);
        end while (!(!p && c) && per < 3000);
    endtask

    // Source periods by requirement: 0 DCO, 1 first crystal, 2 second crystal.
    function automatic int src_per(input int s);
        return (s == 0) ? 8 : (s == 1) ? 20 : 12;
    endfunction
    function automatic int main_map(input int sel, input bit three);
        if (sel < 2) return 0;
        if (sel == 3) return 1;
        return three ? 2 : 1;
    endfunction
    function automatic int sub_map(input int sel, input bit three);
        if (sel == 0) return 0;
        return three ? 2 : 1;
    endfunction

    // main_sel, main_div, sub_sel, sub_div, aux_div, then A periods main/sub/aux.
    localparam logic [32:0] VEC [0:4] = '{
        {2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 8'd8,   8'd8,  8'd20},
        {2'd1, 2'd1, 1'b1, 2'd0, 2'd1, 8'd16,  8'd12, 8'd40},
        {2'd2, 2'd2, 1'b1, 2'd3, 2'd2, 8'd48,  8'd96, 8'd80},
        {2'd3, 2'd3, 1'b0, 2'd1, 2'd3, 8'd160, 8'd16, 8'd160},
        {2'd2, 2'd0, 1'b0, 2'd2, 2'd0, 8'd12,  8'd32, 8'd20}
    };

    task automatic en_chk(input string tag, input logic [3:0] ea, input logic [3:0] eb);
        repeat (3) @(negedge clk);
        chk(a_xt1 == ea[3], {tag, " R9 A xt1_en"},   a_xt1, ea[3]);
        chk(a_xt2 == ea[2], {tag, " R8 A xt2_en"},   a_xt2, ea[2]);
        chk(a_dco == ea[1], {tag, " R10 A dco_en"},  a_dco, ea[1]);
        chk(a_dcg == ea[0], {tag, " R10 A dcgen_en"}, a_dcg, ea[0]);
        chk(b_xt1 == eb[3], {tag, " R9 B xt1_en"},   b_xt1, eb[3]);
        chk(b_xt2 == eb[2], {tag, " R8 B xt2_en"},   b_xt2, eb[2]);
        chk(b_dco == eb[1], {tag, " R10 B dco_en"},  b_dco, eb[1]);
        chk(b_dcg == eb[0], {tag, " R10 B dcgen_en"}, b_dcg, eb[0]);
    endtask

    // Minimum high width monitor on the main clock of copy A (R11).
    bit mon_on = 1'b0;
    int hcnt = 0;
    int minh = 1000;
    always @(negedge clk) begin
        if (mon_on) begin
            if (a_mclk) hcnt++;
            else begin
                if (hcnt > 0 && hcnt < minh) minh = hcnt;
                hcnt = 0;
            end
        end
    end

    initial begin
        int per, hi, rises;
        logic p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset values
        rd_addr = 1'b0; #1;
        chk(a_rd == 8'h0C, "R1 reg0 reset", a_rd, 8'h0C);
        @(negedge clk); rd_addr = 1'b1; #1;
        chk(a_rd == 8'h00, "R1 reg1 reset", a_rd, 8'h00);
        en_chk("R1 reset", 4'b0011, 4'b0011);

        // R2 reserved bits
        wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
        @(negedge clk); rd_addr = 1'b0; #1;
        chk(a_rd == 8'h3F, "R2 reg0 readback", a_rd, 8'h3F);
        @(negedge clk); rd_addr = 1'b1; #1;
        chk(a_rd == 8'h7F, "R2 reg1 readback", a_rd, 8'h7F);
        wr(1'b0, 8'h0C); wr(1'b1, 8'h00);

        // Vector table: R3 main, R4 sub, R6 aux, R5 duty
        foreach (VEC[i]) begin
            int ms, md, ss, sd, ad;
            ms = int'(VEC[i][32:31]); md = int'(VEC[i][30:29]);
            ss = int'(VEC[i][28]);    sd = int'(VEC[i][27:26]); ad = int'(VEC[i][25:24]);
            wr(1'b0, 8'(8'h0C | (ad << 4)));
            wr(1'b1, 8'(ms | (md << 2) | (ss << 4) | (sd << 5)));
            repeat (400) @(negedge clk);
            measure(0, 0, per, hi);
            chk(per == int'(VEC[i][23:16]), "R3 A main period", per, int'(VEC[i][23:16]));
            chk(hi * 2 == per, "R5 A main duty", hi * 2, per);
            measure(0, 1, per, hi);
            chk(per == int'(VEC[i][15:8]), "R4 A sub period", per, int'(VEC[i][15:8]));
            chk(hi * 2 == per, "R5 A sub duty", hi * 2, per);
            measure(0, 2, per, hi);
            chk(per == int'(VEC[i][7:0]), "R6 A aux period", per, int'(VEC[i][7:0]));
            measure(1, 0, per, hi);
            chk(per == src_per(main_map(ms, 1'b0)) << md, "R3 B main period",
                per, src_per(main_map(ms, 1'b0)) << md);
            measure(1, 1, per, hi);
            chk(per == src_per(sub_map(ss, 1'b0)) << sd, "R4 B sub period",
                per, src_per(sub_map(ss, 1'b0)) << sd);
            chk(hi * 2 == per, "R5 B sub duty", hi * 2, per);
            measure(1, 2, per, hi);
            chk(per == 20 << ad, "R6 B aux period", per, 20 << ad);
        end
        wr(1'b0, 8'h0C); wr(1'b1, 8'h00);
        repeat (100) @(negedge clk);

        // R7 gating: main and sub held low, aux still running
        cpu_off = 1'b1; smclk_off = 1'b1;
        repeat (50) @(negedge clk);
        rises = 0; p = a_aclk;
        hi = 0;
        repeat (400) begin
            @(negedge clk);
            if (a_mclk || a_smclk || b_mclk || b_smclk) hi++;
            if (!p && a_aclk) rises++;
            p = a_aclk;
        end
        chk(hi == 0, "R7 main/sub stay low", hi, 0);
        chk(rises == 20, "R7 aux keeps running", rises, 20);
        cpu_off = 1'b0; smclk_off = 1'b0;

        // R8 R9 R10 run requests
        en_chk("c1", 4'b0011, 4'b0011);
        wr(1'b1, 8'h02);
        en_chk("c2 main sel2", 4'b0111, 4'b1011);
        cpu_off = 1'b1;
        en_chk("c3 cpu off", 4'b0011, 4'b0011);
        wr(1'b1, 8'h10);
        en_chk("c4 sub sel1", 4'b0100, 4'b1000);
        smclk_off = 1'b1;
        en_chk("c5 all stopped", 4'b0000, 4'b0000);
        dcgen_off = 1'b0; xt1_off = 1'b0;
        en_chk("c6 bias on", 4'b1001, 4'b1001);
        wr(1'b0, 8'h04);
        en_chk("c7 xt2 off clear", 4'b1101, 4'b1001);
        wr(1'b0, 8'h0C); xt1_off = 1'b1; dcgen_off = 1'b1; cpu_off = 1'b0;
        wr(1'b1, 8'h03);
        en_chk("c8 main sel3", 4'b1000, 4'b1000);
        smclk_off = 1'b0;
        wr(1'b1, 8'h00);
        repeat (200) @(negedge clk);

        // R11 rapid reselection: no runt high pulses on main clock
        mon_on = 1'b1;
        for (int k = 0; k < 12; k++) begin
            wr(1'b1, 8'((k % 4) | (((k * 3) % 4) << 2)));
            repeat (17 + k * 5) @(negedge clk);
        end
        wr(1'b1, 8'h00);
        repeat (400) @(negedge clk);
        mon_on = 1'b0;
        chk(minh >= 4, "R11 min high width", minh, 4);
        measure(0, 0, per, hi);
        chk(per == 8, "R11 settles after reselection", per, 8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule